// File: doc/BRIEF.md
# Rename Register Free List

This block holds the physical register indices that the renaming stage of an out-of-order core may hand out. Integer and floating-point registers share one index space: integer indices come first and floating-point indices follow. Each class has its own first-in-first-out pool. The rename stage takes an index from a pool through that class's allocate port. Retired or squashed mappings come back through a release port.

There are two kinds of release port. The generic port looks at the value of the freed index and picks the pool from it. It drops indices that fall past the end of the register file, and it drops the hardwired zero registers. The per-class release ports push whatever index they are given. Each pool reports its occupancy and whether it is empty. Two sticky error flags record allocation from an empty pool and a push into a full pool (a double free).

After reset, each pool contains every physical index of its class that is not the initial home of an architectural register. The hardwired zero registers are left out.

Top module: `rename_free_list`

## Requirements
- R1: After reset, the integer pool holds indices NUM_LOG_INT to NUM_PHYS_INT-1 in ascending order, oldest first. The floating-point pool holds NUM_PHYS_INT+NUM_LOG_FP to NUM_PHYS_INT+NUM_PHYS_FP-1 in the same way. The integer zero index ZERO_REG is left out, and so is the floating-point zero index ZERO_REG+NUM_PHYS_INT when FP_HAS_ZERO is 1. Both error flags are low.
- R2: When an allocate request hits a non-empty pool, the valid output goes high in the same cycle and the index output shows the entry that has been in the pool longest. The entry leaves the pool at the next clock edge.
- R3: A generic release pushes an index below NUM_PHYS_INT into the integer pool. It pushes an index from NUM_PHYS_INT to NUM_PHYS_INT+NUM_PHYS_FP-1 into the floating-point pool.
- R4: A generic release of an index of NUM_PHYS_INT+NUM_PHYS_FP or above changes neither pool.
- R5: A generic release never inserts ZERO_REG. It also never inserts ZERO_REG+NUM_PHYS_INT when FP_HAS_ZERO is 1.
- R6: A class-specific release pushes its index into that class's pool without any range or zero-register filtering.
- R7: Each pool's count output equals the number of entries it holds. Its empty output is high exactly when that count is zero.
- R8: An allocate request to an empty pool leaves the valid output low and drives the index output to 0. It changes neither pool, and it sets the underflow flag, which stays high until reset.
- R9: A push that finds no room in its pool is discarded. It sets the overflow flag, which stays high until reset.
- R10: An allocation and a release to the same pool in one cycle both take effect. The count is unchanged, and the allocated index is the previous oldest entry, never the index being released.
- R11: A generic release and a class-specific release aimed at the same pool in one cycle both enter that pool, the generic one first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_alloc_req | input | 1 | Request an integer register |
| int_alloc_vld | output | 1 | Integer allocation granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer index (0 when not granted) |
| fp_alloc_req | input | 1 | Request a floating-point register |
| fp_alloc_vld | output | 1 | Floating-point allocation granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted floating-point index (0 when not granted) |
| rel_vld | input | 1 | Generic release strobe |
| rel_idx | input | IDX_W | Index freed on the generic port |
| int_rel_vld | input | 1 | Integer-only release strobe |
| int_rel_idx | input | IDX_W | Index pushed into the integer pool |
| fp_rel_vld | input | 1 | Floating-point-only release strobe |
| fp_rel_idx | input | IDX_W | Index pushed into the floating-point pool |
| int_empty | output | 1 | Integer pool holds nothing |
| fp_empty | output | 1 | Floating-point pool holds nothing |
| int_count | output | $clog2(NUM_PHYS_INT+1) | Integer pool occupancy |
| fp_count | output | $clog2(NUM_PHYS_FP+1) | Floating-point pool occupancy |
| underflow_err | output | 1 | Sticky: allocation from an empty pool |
| overflow_err | output | 1 | Sticky: push into a full pool |

## Verification
The hardest state to reach from the ports is a pool that is completely full and then receives more pushes, sometimes together with an allocation in the same cycle, where one push fits and the next does not. Random traffic rarely fills a pool, because allocations drain it. The bench therefore runs phases of random traffic with a strong bias toward releases, so that both pools sit at capacity for long stretches. It also runs a directed sequence that fills the floating-point pool through its own port before pushing once more. A reference model built from queues predicts every grant, index, count and flag on every cycle.

// File: rtl/rfl_pkg.sv
// Shared definitions for the rename free list.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package rfl_pkg;

    // Destination decided for an index arriving on the generic release port.
    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_INT  = 2'd1,
        DEST_FP   = 2'd2
    } rel_dest_e;

endpackage

// File: rtl/rfl_route.sv
// Routes an index from the generic release port to one pool by its value.
// An index past the end of the register file goes nowhere, and so do the
// hardwired zero registers.
// Assumes: integer indices come first and floating-point indices follow.
module rfl_route
    import rfl_pkg::*;
#(
    parameter int IDX_W        = 5,
    parameter int NUM_PHYS_INT = 16,
    parameter int NUM_PHYS_FP  = 12,
    parameter int ZERO_REG     = 0,
    parameter bit FP_HAS_ZERO  = 1'b1
) (
    input  logic             rel_vld,
    input  logic [IDX_W-1:0] rel_idx,
    output rel_dest_e        dest
);
    localparam int TOTAL   = NUM_PHYS_INT + NUM_PHYS_FP;
    localparam int FP_ZERO = ZERO_REG + NUM_PHYS_INT;

    // Classify the released index.
    always_comb begin
        dest = DEST_NONE;
        if (rel_vld) begin
            if (int'(rel_idx) < NUM_PHYS_INT) begin
                if (int'(rel_idx) != ZERO_REG) dest = DEST_INT;
            end else if (int'(rel_idx) < TOTAL) begin
                if (!(FP_HAS_ZERO && int'(rel_idx) == FP_ZERO)) dest = DEST_FP;
            end
        end
    end
endmodule

// File: rtl/rfl_pool.sv
// One circular FIFO pool of free physical indices. It has one pop port and
// two push ports; push0 is stored before push1 in the same cycle. A pop
// reads the head combinationally. A push with no room is discarded and
// raises a sticky overflow flag. A pop from an empty pool raises a sticky
// underflow flag. At reset the pool is loaded with BASE+LOG upward,
// skipping SKIP_IDX when SKIP_EN is set.
// Assumes: DEPTH >= 1 and LOG <= DEPTH.
module rfl_pool #(
    parameter int DEPTH    = 16,
    parameter int IDX_W    = 5,
    parameter int BASE     = 0,
    parameter int LOG      = 8,
    parameter bit SKIP_EN  = 1'b1,
    parameter int SKIP_IDX = 0,
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    output logic             alloc_vld,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             push0,
    input  logic [IDX_W-1:0] push0_idx,
    input  logic             push1,
    input  logic [IDX_W-1:0] push1_idx,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             underflow_err,
    output logic             overflow_err
);
    function automatic int preload_count();
        int c = 0;
        for (int v = BASE + LOG; v < BASE + DEPTH; v++)
            if (!(SKIP_EN && v == SKIP_IDX)) c++;
        return c;
    endfunction

    localparam int PRE_N = preload_count();

    function automatic logic [IDX_W-1:0] preload_val(int slot);
        int v = BASE + LOG + slot;
        if (SKIP_EN && SKIP_IDX >= BASE + LOG && v >= SKIP_IDX) v++;
        return IDX_W'(v);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic [IDX_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head, tail, wr1_ptr;
    logic [CNT_W:0]   room;
    logic             pop, acc0, acc1;

    // Decide which requests the pool can honour this cycle.
    always_comb begin
        pop     = alloc_req && (count != '0);
        room    = (CNT_W+1)'(DEPTH) - {1'b0, count} + (CNT_W+1)'(pop);
        acc0    = push0 && (room != '0);
        acc1    = push1 && (room > (acc0 ? (CNT_W+1)'(1) : '0));
        wr1_ptr = acc0 ? ptr_inc(tail) : tail;
    end

    assign alloc_vld = pop;
    assign alloc_idx = pop ? mem[head] : '0;
    assign empty     = (count == '0);

    // Pointer, occupancy and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head          <= '0;
            tail          <= PTR_W'(PRE_N % DEPTH);
            count         <= CNT_W'(PRE_N);
            underflow_err <= 1'b0;
            overflow_err  <= 1'b0;
        end else begin
            if (pop) head <= ptr_inc(head);
            tail  <= acc1 ? ptr_inc(wr1_ptr) : wr1_ptr;
            count <= count - CNT_W'(pop) + CNT_W'(acc0) + CNT_W'(acc1);
            if (alloc_req && !pop) underflow_err <= 1'b1;
            if ((push0 && !acc0) || (push1 && !acc1)) overflow_err <= 1'b1;
        end
    end

    // Storage: preload on reset, otherwise write accepted pushes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i < PRE_N) ? preload_val(i) : '0;
        end else begin
            if (acc0) mem[tail] <= push0_idx;
            if (acc1) mem[wr1_ptr] <= push1_idx;
        end
    end

    // R8
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && empty) |=> underflow_err);
    // R8
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    // R9
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push0 && push1 && !alloc_req && int'(count) >= DEPTH - 1) |=> overflow_err);
    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);
    // R10
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && push0 && !push1) |=> count == $past(count));
    // R2
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && !push0 && !push1) |=> count == $past(count) - CNT_W'(1));
    // R7
    empty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !alloc_vld);
endmodule

// File: rtl/rename_free_list.sv
// Free-register pools for renaming: one integer and one floating-point FIFO
// over a unified physical index space. The generic release port routes by
// value; the class ports push unconditionally. The generic push goes into a
// pool ahead of that class's own push in the same cycle.
// Assumes: ZERO_REG < NUM_PHYS_INT and ZERO_REG < NUM_PHYS_FP.
module rename_free_list
    import rfl_pkg::*;
#(
    parameter int NUM_LOG_INT  = 8,
    parameter int NUM_PHYS_INT = 16,
    parameter int NUM_LOG_FP   = 4,
    parameter int NUM_PHYS_FP  = 12,
    parameter int ZERO_REG     = 0,
    parameter bit FP_HAS_ZERO  = 1'b1,
    localparam int TOTAL       = NUM_PHYS_INT + NUM_PHYS_FP,
    localparam int IDX_W       = $clog2(TOTAL),
    localparam int CI_W        = $clog2(NUM_PHYS_INT + 1),
    localparam int CF_W        = $clog2(NUM_PHYS_FP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_alloc_req,
    output logic             int_alloc_vld,
    output logic [IDX_W-1:0] int_alloc_idx,
    input  logic             fp_alloc_req,
    output logic             fp_alloc_vld,
    output logic [IDX_W-1:0] fp_alloc_idx,
    input  logic             rel_vld,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             int_rel_vld,
    input  logic [IDX_W-1:0] int_rel_idx,
    input  logic             fp_rel_vld,
    input  logic [IDX_W-1:0] fp_rel_idx,
    output logic             int_empty,
    output logic             fp_empty,
    output logic [CI_W-1:0]  int_count,
    output logic [CF_W-1:0]  fp_count,
    output logic             underflow_err,
    output logic             overflow_err
);
    rel_dest_e dest;
    logic      int_uf, int_of, fp_uf, fp_of;

    rfl_route #(
        .IDX_W(IDX_W), .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
        .ZERO_REG(ZERO_REG), .FP_HAS_ZERO(FP_HAS_ZERO)
    ) u_route (
        .rel_vld(rel_vld), .rel_idx(rel_idx), .dest(dest)
    );

    rfl_pool #(
        .DEPTH(NUM_PHYS_INT), .IDX_W(IDX_W), .BASE(0), .LOG(NUM_LOG_INT),
        .SKIP_EN(1'b1), .SKIP_IDX(ZERO_REG)
    ) u_int_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(int_alloc_req), .alloc_vld(int_alloc_vld), .alloc_idx(int_alloc_idx),
        .push0(dest == DEST_INT), .push0_idx(rel_idx),
        .push1(int_rel_vld), .push1_idx(int_rel_idx),
        .empty(int_empty), .count(int_count),
        .underflow_err(int_uf), .overflow_err(int_of)
    );

    rfl_pool #(
        .DEPTH(NUM_PHYS_FP), .IDX_W(IDX_W), .BASE(NUM_PHYS_INT), .LOG(NUM_LOG_FP),
        .SKIP_EN(FP_HAS_ZERO), .SKIP_IDX(ZERO_REG + NUM_PHYS_INT)
    ) u_fp_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(fp_alloc_req), .alloc_vld(fp_alloc_vld), .alloc_idx(fp_alloc_idx),
        .push0(dest == DEST_FP), .push0_idx(rel_idx),
        .push1(fp_rel_vld), .push1_idx(fp_rel_idx),
        .empty(fp_empty), .count(fp_count),
        .underflow_err(fp_uf), .overflow_err(fp_of)
    );

    assign underflow_err = int_uf | fp_uf;
    assign overflow_err  = int_of | fp_of;

    // R4
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && int'(rel_idx) >= TOTAL && !int_rel_vld && !fp_rel_vld
         && !int_alloc_req && !fp_alloc_req)
        |=> (int_count == $past(int_count)) && (fp_count == $past(fp_count)));
    // R5
    int_zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && int'(rel_idx) == ZERO_REG && !int_rel_vld && !int_alloc_req)
        |=> int_count == $past(int_count));
    // R3
    route_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && int'(rel_idx) < NUM_PHYS_INT && int'(rel_idx) != ZERO_REG
         && !int_rel_vld && !int_alloc_req && !int_empty && !overflow_err)
        |=> int_count == $past(int_count) + CI_W'(1) || overflow_err);
endmodule

// File: tb/rename_free_list_test.sv
// Bench: directed corner cases followed by biased random traffic from
// $urandom, all checked against a queue-based reference model.
module rename_free_list_test;
    localparam int NLI = 8, NPI = 16, NLF = 4, NPF = 12, ZR = 0;
    localparam int TOTAL = NPI + NPF;
    localparam int IW = $clog2(TOTAL);
    localparam int CIW = $clog2(NPI + 1), CFW = $clog2(NPF + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ia_req, fa_req, rel_vld, irel_vld, frel_vld;
    logic [IW-1:0] rel_idx, irel_idx, frel_idx;
    logic ia_vld, fa_vld, i_empty, f_empty, uf_err, of_err;
    logic [IW-1:0] ia_idx, fa_idx;
    logic [CIW-1:0] i_cnt;
    logic [CFW-1:0] f_cnt;

    int errors = 0, checks = 0, cyc = 0;
    int qi[$], qf[$];
    bit uf_m = 0, of_m = 0;

    always #2.5 clk = ~clk;

    rename_free_list #(
        .NUM_LOG_INT(NLI), .NUM_PHYS_INT(NPI), .NUM_LOG_FP(NLF),
        .NUM_PHYS_FP(NPF), .ZERO_REG(ZR), .FP_HAS_ZERO(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .int_alloc_req(ia_req), .int_alloc_vld(ia_vld), .int_alloc_idx(ia_idx),
        .fp_alloc_req(fa_req), .fp_alloc_vld(fa_vld), .fp_alloc_idx(fa_idx),
        .rel_vld(rel_vld), .rel_idx(rel_idx),
        .int_rel_vld(irel_vld), .int_rel_idx(irel_idx),
        .fp_rel_vld(frel_vld), .fp_rel_idx(frel_idx),
        .int_empty(i_empty), .fp_empty(f_empty),
        .int_count(i_cnt), .fp_count(f_cnt),
        .underflow_err(uf_err), .overflow_err(of_err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // 0 = dropped, 1 = integer pool, 2 = floating-point pool
    function automatic int route(int idx);
        if (idx < NPI) return (idx == ZR) ? 0 : 1;
        if (idx < TOTAL) return (idx == ZR + NPI) ? 0 : 2;
        return 0;
    endfunction

    task automatic idle();
        ia_req = 0; fa_req = 0; rel_vld = 0; irel_vld = 0; frel_vld = 0;
        rel_idx = '0; irel_idx = '0; frel_idx = '0;
    endtask

    task automatic model_push(ref int q[$], input int depth, input int v);
        if (q.size() < depth) q.push_back(v);
        else of_m = 1;
    endtask

    // Check the outputs for the current inputs, advance the model and the clock.
    task automatic cycle();
        int d;
        #1;
        chk("R2 int_alloc_vld", int'(ia_vld), int'(ia_req && qi.size() > 0));
        if (ia_req && qi.size() > 0) chk("R2 int_alloc_idx", int'(ia_idx), qi[0]);
        if (ia_req && qi.size() == 0) chk("R8 int_alloc_idx", int'(ia_idx), 0);
        chk("R2 fp_alloc_vld", int'(fa_vld), int'(fa_req && qf.size() > 0));
        if (fa_req && qf.size() > 0) chk("R2 fp_alloc_idx", int'(fa_idx), qf[0]);
        chk("R7 int_count", int'(i_cnt), qi.size());
        chk("R7 fp_count", int'(f_cnt), qf.size());
        chk("R7 int_empty", int'(i_empty), int'(qi.size() == 0));
        chk("R7 fp_empty", int'(f_empty), int'(qf.size() == 0));
        chk("R8 underflow_err", int'(uf_err), int'(uf_m));
        chk("R9 overflow_err", int'(of_err), int'(of_m));
        if (ia_req) begin if (qi.size() > 0) void'(qi.pop_front()); else uf_m = 1; end
        if (fa_req) begin if (qf.size() > 0) void'(qf.pop_front()); else uf_m = 1; end
        d = rel_vld ? route(int'(rel_idx)) : 0;
        if (d == 1) model_push(qi, NPI, int'(rel_idx));
        if (irel_vld) model_push(qi, NPI, int'(irel_idx));
        if (d == 2) model_push(qf, NPF, int'(rel_idx));
        if (frel_vld) model_push(qf, NPF, int'(frel_idx));
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected=0", cyc);
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int v = NLI; v < NPI; v++) if (v != ZR) qi.push_back(v);
        for (int v = NPI + NLF; v < TOTAL; v++) if (v != ZR + NPI) qf.push_back(v);
        #1;
        chk("R1 int_count reset", int'(i_cnt), 8);
        chk("R1 fp_count reset", int'(f_cnt), 8);
        chk("R1 flags reset", int'(uf_err) + int'(of_err), 0);
        chk("R1 int_empty reset", int'(i_empty), 0);
        @(negedge clk);

        // R1/R2: drain integer pool in preload order
        for (int k = 0; k < 8; k++) begin
            idle(); ia_req = 1;
            #1 chk("R1 int preload order", int'(ia_idx), 8 + k);
            cycle();
        end
        // R8: allocate from empty pool
        idle(); ia_req = 1;
        #1 chk("R8 no grant on empty", int'(ia_vld), 0);
        cycle();
        idle(); #1 chk("R8 underflow sticky", int'(uf_err), 1);
        chk("R8 pool unchanged", int'(i_cnt), 0);
        cycle();

        // R5: zero registers dropped by generic port
        idle(); rel_vld = 1; rel_idx = IW'(ZR); cycle();
        idle(); rel_vld = 1; rel_idx = IW'(ZR + NPI); cycle();
        chk("R5 int zero dropped", int'(i_cnt), 0);
        chk("R5 fp zero dropped", int'(f_cnt), 8);
        // R4: out-of-range index ignored
        idle(); rel_vld = 1; rel_idx = IW'(30); cycle();
        chk("R4 int untouched", int'(i_cnt), 0);
        chk("R4 fp untouched", int'(f_cnt), 8);
        // R3: routing by value
        idle(); rel_vld = 1; rel_idx = IW'(5); cycle();
        chk("R3 int routed", int'(i_cnt), 1);
        idle(); rel_vld = 1; rel_idx = IW'(21); cycle();
        chk("R3 fp routed", int'(f_cnt), 9);
        // R6: class port takes the zero index
        idle(); irel_vld = 1; irel_idx = IW'(ZR); cycle();
        chk("R6 class push count", int'(i_cnt), 2);
        idle(); ia_req = 1; cycle();
        idle(); ia_req = 1; #1 chk("R6 zero index returned", int'(ia_idx), ZR);
        cycle();
        // R11: generic and class push same cycle, generic first
        idle(); rel_vld = 1; rel_idx = IW'(3); irel_vld = 1; irel_idx = IW'(7); cycle();
        chk("R11 both pushed", int'(i_cnt), 2);
        idle(); ia_req = 1; #1 chk("R11 generic first", int'(ia_idx), 3);
        cycle();
        idle(); ia_req = 1; #1 chk("R11 class second", int'(ia_idx), 7);
        cycle();
        // R10: allocate and release together
        idle(); rel_vld = 1; rel_idx = IW'(9); cycle();
        idle(); ia_req = 1; rel_vld = 1; rel_idx = IW'(11);
        #1 chk("R10 old head popped", int'(ia_idx), 9);
        cycle();
        chk("R10 count unchanged", int'(i_cnt), 1);
        idle(); ia_req = 1; #1 chk("R10 released next", int'(ia_idx), 11);
        cycle();
        // R9: overfill floating-point pool
        while (qf.size() < NPF) begin
            idle(); frel_vld = 1; frel_idx = IW'(17); cycle();
        end
        idle(); frel_vld = 1; frel_idx = IW'(18); cycle();
        chk("R9 overflow set", int'(of_err), 1);
        chk("R9 push discarded", int'(f_cnt), NPF);

        // Random phases with shifting bias between allocation and release
        for (int ph = 0; ph < 8; ph++) begin
            int pa = (ph % 2 == 0) ? 15 : 70;
            for (int n = 0; n < 500; n++) begin
                ia_req   = ($urandom_range(99) < pa);
                fa_req   = ($urandom_range(99) < pa);
                rel_vld  = ($urandom_range(99) < 60);
                rel_idx  = IW'($urandom_range(31));
                irel_vld = ($urandom_range(99) < 30);
                irel_idx = IW'($urandom_range(NPI - 1));
                frel_vld = ($urandom_range(99) < 30);
                frel_idx = IW'(NPI + $urandom_range(NPF - 1));
                cycle();
            end
        end
        idle();
        summary();
    end
endmodule